// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches the serial receive stream ahead of the byte demultiplexer. It counts bit periods in which the incoming data does not change. When a fixed run of such periods builds up, it raises a loss-of-signal flag. The flag drops on the next data transition, or at once when software or an upstream supervisor pulses the clear input.

A second path serves an optical module that reports its own signal loss through an active-low input. While that input is low, the data handed to the demultiplexer is forced to zero. A clock-select output also tells the external clock multiplexer to run the receive side from the transmit clock, so downstream logic never loses its clock.

The transmit-side bit clock is divided down inside the block to a byte-rate fallback clock for that multiplexer. The transition detector always looks at the raw line data, before the forcing gate. Forced zeros therefore never count as a quiet line.

Top module: `line_los_monitor`

## Requirements
- R1: While rst_n is low, los_flag, ser_dout, use_tx_clk and fb_byte_clk are all 0.
- R2: los_flag goes to 1 on the rising clk_bit edge that completes 128 consecutive edges without a transition on ser_din, and not one edge earlier. A transition is a sample that differs from the sample taken at the previous edge; the first edge after reset counts as transition-free.
- R3: A transition on ser_din resets the run count to zero and drives los_flag to 0 on that same edge.
- R4: clr_los high at an edge forces los_flag to 0 and restarts the run count from zero; los_flag cannot rise while clr_los is held.
- R5: The run count saturates: with constant data los_flag stays 1 indefinitely and never falls back through a counter wrap.
- R6: ser_dout is the value of ser_din registered on the edge when sig_ok is 1, and 0 when sig_ok was 0 at that edge.
- R7: The forcing gate does not feed the detector: toggling data while sig_ok is 0 keeps los_flag at 0, and constant data while sig_ok is 0 still raises it after 128 edges.
- R8: use_tx_clk is 1 exactly in the cycle after an edge at which sig_ok was 0, and 0 otherwise (1 selects the transmit clock for the receive side).
- R9: fb_byte_clk is the transmit bit clock divided by 8: after reset it is 0 for the first 4 tx_clk edges, then 1 for 4, repeating with period 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Receive serial bit clock |
| tx_clk | input | 1 | Transmit bit clock, source of the fallback byte clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_din | input | 1 | Raw serial receive data |
| clr_los | input | 1 | Active-high clear of the loss-of-signal flag |
| sig_ok | input | 1 | External signal-present indication, low means signal lost |
| los_flag | output | 1 | High after 128 transition-free bit periods |
| ser_dout | output | 1 | Gated serial data to the demultiplexer |
| use_tx_clk | output | 1 | Clock-select control, 1 = run receive side on transmit clock |
| fb_byte_clk | output | 1 | Transmit clock divided by 8 |

## Verification
The assertions assume that ser_din, clr_los and sig_ok are synchronous to clk_bit and are stable around its rising edge. They also assume that reset is released away from an edge. The bench drives every input on the falling edge and derives clk_bit and tx_clk from one source, so both domains advance together and the divider phase can be predicted. The bench assumes nothing about the data pattern: it mixes long constant runs, single toggles and random data, with and without sig_ok.

// File: rtl/los_pkg.sv
package los_pkg;

    // Default number of transition-free bit periods that declare a quiet line
    localparam int unsigned LOS_RUN_DEFAULT  = 128;
    // Default ratio between transmit bit clock and fallback byte clock
    localparam int unsigned BYTE_DIV_DEFAULT = 8;

    // Registered outputs of the forcing gate
    typedef struct packed {
        logic data;
        logic use_tx;
    } gate_st_t;

endpackage

// File: rtl/los_run_counter.sv
module los_run_counter #(
    parameter int unsigned RUN_LIMIT = los_pkg::LOS_RUN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic quiet
);
    localparam int unsigned CW = $clog2(RUN_LIMIT + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LIMIT);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          flag;
        logic          prev;
        logic          seen;
    } run_st_t;

    run_st_t st_d, st_q;
    logic    toggled;

    always_comb begin
        st_d    = st_q;
        toggled = st_q.seen && (din != st_q.prev);
        if (clr || toggled) begin
            st_d.run  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (st_q.run != RUN_MAX) begin
                st_d.run = st_q.run + 1'b1;
            end
            if (st_d.run == RUN_MAX) begin
                st_d.flag = 1'b1;
            end
        end
        st_d.prev = din;
        st_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quiet = st_q.flag;

endmodule

// File: rtl/los_data_gate.sv
module los_data_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic sig_ok,
    output logic dout,
    output logic use_tx
);
    import los_pkg::*;

    gate_st_t g_d, g_q;

    always_comb begin
        g_d.data   = sig_ok & din;
        g_d.use_tx = ~sig_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign dout   = g_q.data;
    assign use_tx = g_q.use_tx;

endmodule

// File: rtl/los_byte_div.sv
module los_byte_div #(
    parameter int unsigned DIV = los_pkg::BYTE_DIV_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk
);
    localparam int unsigned DW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam logic [DW-1:0] LAST  = DW'(DIV - 1);
    localparam logic [DW-1:0] HALFV = DW'(HALF);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign div_clk = (cnt_q >= HALFV);

endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor #(
    parameter int unsigned RUN_LIMIT = los_pkg::LOS_RUN_DEFAULT,
    parameter int unsigned BYTE_DIV  = los_pkg::BYTE_DIV_DEFAULT
) (
    input  logic clk_bit,
    input  logic tx_clk,
    input  logic rst_n,
    input  logic ser_din,
    input  logic clr_los,
    input  logic sig_ok,
    output logic los_flag,
    output logic ser_dout,
    output logic use_tx_clk,
    output logic fb_byte_clk
);

    // Detector sees raw line data, ahead of the forcing gate
    los_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .din   (ser_din),
        .clr   (clr_los),
        .quiet (los_flag)
    );

    los_data_gate u_gate (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .din    (ser_din),
        .sig_ok (sig_ok),
        .dout   (ser_dout),
        .use_tx (use_tx_clk)
    );

    los_byte_div #(.DIV(BYTE_DIV)) u_div (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .div_clk (fb_byte_clk)
    );

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk #(
    parameter int unsigned RUN_LIMIT = los_pkg::LOS_RUN_DEFAULT
) (
    input logic clk_bit,
    input logic rst_n,
    input logic ser_din,
    input logic clr_los,
    input logic sig_ok,
    input logic los_flag,
    input logic ser_dout,
    input logic use_tx_clk
);
    // Independent quiet-run tracker, used instead of a long $past window
    int unsigned quiet_c;
    logic        last_c;
    logic        have_c;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            quiet_c <= 0;
            last_c  <= 1'b0;
            have_c  <= 1'b0;
        end else begin
            if (clr_los || (have_c && ser_din != last_c)) begin
                quiet_c <= 0;
            end else if (quiet_c < RUN_LIMIT) begin
                quiet_c <= quiet_c + 1;
            end
            last_c <= ser_din;
            have_c <= 1'b1;
        end
    end

    // R2 R3 R5
    flag_matches_run_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        los_flag == (quiet_c == RUN_LIMIT));

    // R4
    clear_drops_flag_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        clr_los |=> !los_flag);

    // R6
    forced_zero_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !sig_ok |=> !ser_dout);

    // R8
    select_tx_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !sig_ok |=> use_tx_clk);

    // R8
    select_rx_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        sig_ok |=> !use_tx_clk);

endmodule

bind line_los_monitor los_monitor_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (.*);

// File: tb/tb_line_los_monitor.sv
`timescale 1ns/1ps
module tb_line_los_monitor;

    logic clk = 1'b0;
    logic rst_n;
    logic ser_din, clr_los, sig_ok;
    logic los_flag, ser_dout, use_tx_clk, fb_byte_clk;

    int tests = 0;
    int fails = 0;

    // Reference model state
    int m_run;
    bit m_prev, m_seen, m_flag, m_dout, m_sel;
    int m_txc;

    always #10 clk = ~clk;

    line_los_monitor dut (
        .clk_bit    (clk),
        .tx_clk     (clk),
        .rst_n      (rst_n),
        .ser_din    (ser_din),
        .clr_los    (clr_los),
        .sig_ok     (sig_ok),
        .los_flag   (los_flag),
        .ser_dout   (ser_dout),
        .use_tx_clk (use_tx_clk),
        .fb_byte_clk(fb_byte_clk)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_prev = 0; m_seen = 0; m_flag = 0;
        m_dout = 0; m_sel = 0; m_txc = 0;
    endtask

    task automatic model_edge(input bit d, input bit c, input bit ok);
        if (c) begin
            m_run = 0; m_flag = 0;
        end else if (m_seen && d != m_prev) begin
            m_run = 0; m_flag = 0;
        end else begin
            if (m_run < 128) m_run++;
            if (m_run == 128) m_flag = 1;
        end
        m_prev = d; m_seen = 1;
        m_dout = ok ? d : 1'b0;
        m_sel  = !ok;
        m_txc  = (m_txc + 1) % 8;
    endtask

    // One bit period: drive after a falling edge, model on rising, compare on falling
    task automatic step(input bit d, input bit c, input bit ok, input string ftag);
        ser_din = d; clr_los = c; sig_ok = ok;
        @(posedge clk);
        model_edge(d, c, ok);
        @(negedge clk);
        check(los_flag == m_flag, ftag, "los_flag", los_flag, m_flag);
        check(ser_dout == m_dout, "R6", "ser_dout", ser_dout, m_dout);
        check(use_tx_clk == m_sel, "R8", "use_tx_clk", use_tx_clk, m_sel);
        check(fb_byte_clk == (m_txc >= 4), "R9", "fb_byte_clk", fb_byte_clk, int'(m_txc >= 4));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ser_din = 1'b1; clr_los = 1'b0; sig_ok = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        check(los_flag == 0, "R1", "los_flag", los_flag, 0);
        check(ser_dout == 0, "R1", "ser_dout", ser_dout, 0);
        check(use_tx_clk == 0, "R1", "use_tx_clk", use_tx_clk, 0);
        check(fb_byte_clk == 0, "R1", "fb_byte_clk", fb_byte_clk, 0);
        rst_n = 1'b1;

        // R2: 127 quiet edges keep the flag low, the 128th raises it
        for (int i = 0; i < 127; i++) step(1'b0, 1'b0, 1'b1, "R2");
        check(los_flag == 0, "R2", "flag after 127", los_flag, 0);
        step(1'b0, 1'b0, 1'b1, "R2");
        check(los_flag == 1, "R2", "flag after 128", los_flag, 1);

        // R5: saturation, no wrap
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b1, "R5");
        check(los_flag == 1, "R5", "flag held", los_flag, 1);

        // R3: one transition clears it
        step(1'b1, 1'b0, 1'b1, "R3");
        check(los_flag == 0, "R3", "flag after toggle", los_flag, 0);
        for (int i = 0; i < 127; i++) step(1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b1, "R3");
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 1)), 1'b0, 1'b1, "R3");

        // R4: clear pulse, then clear held over a long quiet run
        for (int i = 0; i < 140; i++) step(1'b1, 1'b0, 1'b1, "R2");
        step(1'b1, 1'b1, 1'b1, "R4");
        check(los_flag == 0, "R4", "flag after clear", los_flag, 0);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b1, "R4");
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 1'b1, "R4");

        // R7: forcing does not feed the detector
        for (int i = 0; i < 200; i++) step(1'(i % 2), 1'b0, 1'b0, "R7");
        check(los_flag == 0, "R7", "toggling while forced", los_flag, 0);
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 1'b0, "R7");
        check(los_flag == 1, "R7", "quiet while forced", los_flag, 1);

        // R6 R8: random gating
        for (int i = 0; i < 600; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 20) == 0),
                 1'($urandom_range(0, 3) != 0), "R6");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule